// File: doc/BRIEF.md
# Large-Argument Trigonometric Range Reducer

This block takes one single-precision floating-point angle in radians and reduces it modulo a quarter turn. It returns a 2-bit quadrant and a signed 64-bit fixed-point remainder. The remainder is a fraction of a quarter turn, scaled so that one quarter turn equals 2^62. To turn it into radians, multiply the signed value by π·2^-63 (about 3.406e-19).

The reduction works on the integer significand of the angle. That significand is multiplied by a 96-bit window of a stored 192-bit value of 2/π. The window is chosen by the exponent of the input and then aligned with a funnel shift. The product is truncated, and the quadrant is rounded to nearest, so the remainder lies within half a quarter turn.

Small angles skip the reduction, as do infinities and NaNs. For these inputs the raw input bits are returned and a flag marks the case. The multiply is a shift-add loop that consumes a fixed number of multiplier bits per cycle, so the latency is the same for every input.

An angle is handed over with a valid/ready handshake. A one-cycle done pulse marks the cycle in which the outputs take their new values. The outputs then hold until the next result.

Top module: `rr_reducer`

## Requirements
- R1: `in_ready` is high while the block is idle. An angle is taken on the rising edge where `in_valid` and `in_ready` are both high. `in_ready` stays low until the result appears, and `in_valid` or `in_angle` changes during that time have no effect on the result.
- R2: `out_done` is high for exactly one cycle, `MUL_STEP`-dependent `32/MUL_STEP + 1` rising edges after the accepting edge. Between done pulses, all result outputs hold their values.
- R3: If the magnitude bits `in_angle[30:0]` are at most 0x3F490FDB (π/4), the result is a pass-through: `out_bypass`=1, `out_special`=0, quadrant 0, and `out_remainder` = {32'h0, in_angle}. This covers zeros and subnormals.
- R4: If the exponent field `in_angle[30:23]` is 0xFF (infinity or NaN), the result is a pass-through: `out_special`=1, `out_bypass`=0, quadrant 0, and `out_remainder` = {32'h0, in_angle}.
- R5: When the angle is reduced, the significand word is ia = {1'b1, in_angle[22:0], 8'h00}, and e = in_angle[30:23] − 126. The window word index is e>>5 and the bit shift is e&31.
- R6: The 2/π words, index 0 (most significant) to 5, are 0x28be60db, 0x9391054a, 0x7f09d5f4, 0x7d4d3770, 0x36d8a566, 0x4f10e410. Any index outside 0..5 reads as zero.
  - The window is hi = word[idx−1], mid = word[idx], lo = word[idx+1], with word[idx+2] as the fill word.
  - When the shift is nonzero, each of hi, mid and lo is shifted left by the shift amount and filled from the top of the following word.
- R7: The 64-bit product p is bits 95..32 of the full product ia × {hi, mid, lo}.
- R8: For a non-negative reduced angle, the quadrant is (p[63:62] + p[61]) mod 4. The remainder is p[61:0] read as a 62-bit two's-complement value and sign-extended to 64 bits, so it lies in [−2^61, 2^61).
- R9: For a reduced angle with sign bit `in_angle[31]`=1, both the remainder of R8 and the quadrant of R8 are negated. The quadrant is negated modulo 4.
- R10: After reset, `in_ready`=1, `out_done`=0, and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Angle offered |
| in_ready | output | 1 | Block idle, angle will be taken |
| in_angle | input | 32 | Single-precision angle in radians |
| out_done | output | 1 | One-cycle pulse: new result on the outputs |
| out_quadrant | output | 2 | Quadrant count modulo 4 |
| out_remainder | output | 64 | Signed remainder (quarter turn = 2^62), or raw input bits for a pass-through |
| out_bypass | output | 1 | Small-angle pass-through |
| out_special | output | 1 | Infinity/NaN pass-through |

## Verification
The bench builds the block with `MUL_STEP`=8, so the shift-add loop takes four cycles. This keeps each reduction short enough to sweep every reducible exponent from 126 to 254 with several significand patterns and both signs. The sweep covers every window index from 0 to 4, including zero-shift alignments, the zero hi word at index 0, and the zero fill past the end of the constant at the top exponents. Directed cases cover the π/4 boundary on both sides, subnormals, infinities and NaNs, and changes to `in_valid` while the block is busy.

// File: rtl/rr_pkg.sv
package rr_pkg;
  localparam int WORD_W  = 32;
  localparam int MANT_W  = 23;
  localparam int EXP_W   = 8;
  localparam int WIN_W   = 3 * WORD_W;
  localparam int ACC_W   = WIN_W;
  localparam int P_W     = 2 * WORD_W;
  localparam int NWORDS  = 6;
  localparam int EXP_OFS = 126;
  localparam logic [30:0] QUARTER_PI_MAG = 31'h3F490FDB;

  typedef struct packed {
    logic [1:0]         quad;
    logic signed [63:0] rem;
  } reduce_t;

  // 2/pi, word 0 most significant; anything past the stored words is zero
  function automatic logic [WORD_W-1:0] tpi_word(input int k);
    case (k)
      0: return 32'h28be60db;
      1: return 32'h9391054a;
      2: return 32'h7f09d5f4;
      3: return 32'h7d4d3770;
      4: return 32'h36d8a566;
      5: return 32'h4f10e410;
      default: return '0;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] sig_word(input logic [31:0] a);
    return {1'b1, a[MANT_W-1:0], 8'h00};
  endfunction

  function automatic logic [EXP_W-1:0] exp_rel(input logic [31:0] a);
    return a[30:23] - EXP_W'(EXP_OFS);
  endfunction

  function automatic logic is_small(input logic [31:0] a);
    return a[30:0] <= QUARTER_PI_MAG;
  endfunction

  function automatic logic is_special(input logic [31:0] a);
    return &a[30:23];
  endfunction

  // quadrant rounding and sign application on the truncated product
  function automatic reduce_t finish(input logic [P_W-1:0] p, input logic neg);
    reduce_t r;
    logic [63:0] m;
    logic [1:0]  q;
    q = p[63:62];
    m = {2'b00, p[61:0]};
    if (p[61]) begin
      m = m - 64'h4000_0000_0000_0000;
      q = q + 2'd1;
    end
    if (neg) begin
      m = -m;
      q = -q;
    end
    r.quad = q;
    r.rem  = $signed(m);
    return r;
  endfunction
endpackage

// File: rtl/rr_window.sv
module rr_window
  import rr_pkg::*;
(
  input  logic [31:0]       angle,
  output logic [WORD_W-1:0] ia,
  output logic [WIN_W-1:0]  win
);
  logic [EXP_W-1:0]  e_rel;
  logic [2:0]        word_idx;
  logic [4:0]        bit_sh;
  logic [WORD_W-1:0] w_hi, w_mid, w_lo, w_fill;
  logic [4*WORD_W-1:0] stream, stream_sh;

  assign ia       = sig_word(angle);
  assign e_rel    = exp_rel(angle);
  assign word_idx = e_rel[7:5];
  assign bit_sh   = e_rel[4:0];

  always_comb begin
    w_hi   = (word_idx == 3'd0) ? '0 : tpi_word(int'(word_idx) - 1);
    w_mid  = tpi_word(int'(word_idx));
    w_lo   = tpi_word(int'(word_idx) + 1);
    w_fill = tpi_word(int'(word_idx) + 2);
  end

  // funnel shift of the four words as one stream; top three words kept
  assign stream    = {w_hi, w_mid, w_lo, w_fill};
  assign stream_sh = stream << bit_sh;
  assign win       = stream_sh[4*WORD_W-1 -: WIN_W];
endmodule

// File: rtl/rr_mul_seq.sv
module rr_mul_seq
  import rr_pkg::*;
#(
  parameter int STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] ia_in,
  input  logic [WIN_W-1:0]  w_in,
  output logic [P_W-1:0]    prod_o,
  output logic              fin_o
);
  localparam int N_CYC = WORD_W / STEP;
  localparam int CW    = (N_CYC > 1) ? $clog2(N_CYC) : 1;

  logic [WORD_W-1:0] ia_r;
  logic [ACC_W-1:0]  w_r, acc, acc_nx, chunk_sum;
  logic [CW-1:0]     cnt;
  logic              busy, fin;
  logic              chunk_add;
  logic              last_chunk;
  logic [ACC_W-1:0]  term [STEP];

  generate
    for (genvar j = 0; j < STEP; j++) begin : g_term
      assign term[j] = ia_r[j] ? (w_r << j) : '0;
    end
  endgenerate

  always_comb begin
    chunk_sum = '0;
    for (int j = 0; j < STEP; j++) chunk_sum = chunk_sum + term[j];
  end

  assign acc_nx     = acc + chunk_sum;
  assign chunk_add  = busy;
  assign last_chunk = busy && (cnt == CW'(N_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ia_r <= '0;
      w_r  <= '0;
      acc  <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      fin  <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        ia_r <= ia_in;
        w_r  <= w_in;
        acc  <= '0;
        cnt  <= '0;
        busy <= 1'b1;
      end else if (chunk_add) begin
        acc  <= acc_nx;
        ia_r <= ia_r >> STEP;
        w_r  <= w_r << STEP;
        cnt  <= cnt + 1'b1;
        if (last_chunk) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end
  end

  assign prod_o = acc[ACC_W-1 -: P_W];
  assign fin_o  = fin;
endmodule

// File: rtl/rr_reducer.sv
module rr_reducer
  import rr_pkg::*;
#(
  parameter int MUL_STEP = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_angle,
  output logic        out_done,
  output logic [1:0]  out_quadrant,
  output logic [63:0] out_remainder,
  output logic        out_bypass,
  output logic        out_special
);
  localparam int MUL_CYCLES = WORD_W / MUL_STEP;

  logic              accept;
  logic              busy_r;
  logic [31:0]       angle_r;
  logic              small_r, special_r;
  logic [WORD_W-1:0] ia;
  logic [WIN_W-1:0]  win;
  logic [P_W-1:0]    prod;
  logic              mul_fin;
  logic              pass_thru;
  reduce_t           red;

  assign accept    = in_valid && in_ready;
  assign in_ready  = !busy_r;
  assign pass_thru = small_r || special_r;
  assign red       = finish(prod, angle_r[31]);

  rr_window u_win (
    .angle (in_angle),
    .ia    (ia),
    .win   (win)
  );

  rr_mul_seq #(.STEP(MUL_STEP)) u_mul (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (accept),
    .ia_in  (ia),
    .w_in   (win),
    .prod_o (prod),
    .fin_o  (mul_fin)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_r        <= 1'b0;
      angle_r       <= '0;
      small_r       <= 1'b0;
      special_r     <= 1'b0;
      out_done      <= 1'b0;
      out_quadrant  <= '0;
      out_remainder <= '0;
      out_bypass    <= 1'b0;
      out_special   <= 1'b0;
    end else begin
      out_done <= 1'b0;
      if (accept) begin
        busy_r    <= 1'b1;
        angle_r   <= in_angle;
        special_r <= is_special(in_angle);
        small_r   <= !is_special(in_angle) && is_small(in_angle);
      end else if (mul_fin) begin
        busy_r      <= 1'b0;
        out_done    <= 1'b1;
        out_bypass  <= small_r;
        out_special <= special_r;
        if (pass_thru) begin
          out_quadrant  <= '0;
          out_remainder <= {32'h0, angle_r};
        end else begin
          out_quadrant  <= red.quad;
          out_remainder <= red.rem;
        end
      end
    end
  end
endmodule

// File: rtl/rr_reducer_chk.sv
module rr_reducer_chk #(
  parameter int STEP = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        accept,
  input logic        in_ready,
  input logic        out_done,
  input logic [1:0]  out_quadrant,
  input logic [63:0] out_remainder,
  input logic        out_bypass,
  input logic        out_special
);
  localparam int NC = 32 / STEP;
  logic [7:0] since_acc;

  always_ff @(posedge clk) begin
    if (!rst_n) since_acc <= '0;
    else if (accept) since_acc <= '0;
    else if (since_acc != 8'hFF) since_acc <= since_acc + 8'd1;
  end

  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |=> !out_done);
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> since_acc == 8'(NC + 1));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_done |-> ($stable(out_remainder) && $stable(out_quadrant)));
  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);
  a_r1_ready_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> in_ready);
  a_r3_bypass_zero_quad: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done && out_bypass) |-> (out_quadrant == 2'd0 && out_remainder[63:32] == 32'h0));
  a_r8_rem_range: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done && !out_bypass && !out_special) |->
      ($signed(out_remainder) >= -64'sh2000_0000_0000_0000 &&
       $signed(out_remainder) <= 64'sh2000_0000_0000_0000));
endmodule

bind rr_reducer rr_reducer_chk #(.STEP(MUL_STEP)) u_chk (.*);

// File: tb/rr_reducer_tb.sv
module rr_reducer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int STEP = 8;
  localparam int NC   = 32 / STEP;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_angle = '0;
  logic        out_done;
  logic [1:0]  out_quadrant;
  logic [63:0] out_remainder;
  logic        out_bypass, out_special;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rr_reducer #(.MUL_STEP(STEP)) u_dut (.*);

  localparam logic [31:0] TPI [6] = '{32'h28be60db, 32'h9391054a, 32'h7f09d5f4,
                                      32'h7d4d3770, 32'h36d8a566, 32'h4f10e410};

  function automatic logic [31:0] tw(input int k);
    if (k < 0 || k > 5) return 32'h0;
    return TPI[k];
  endfunction

  task automatic expect_of(input logic [31:0] a, output logic [1:0] q, output logic [63:0] r,
                           output logic byp, output logic spc);
    logic [31:0] ia, h, m, l, x, h2, m2, l2;
    logic [127:0] full;
    logic [63:0] p;
    int e, idx, sh;
    spc = (a[30:23] == 8'hFF);
    byp = !spc && (a[30:0] <= 31'h3F490FDB);
    if (spc || byp) begin
      q = 2'd0; r = {32'h0, a};
      return;
    end
    ia  = (32'(a[22:0]) | 32'h0080_0000) << 8;
    e   = int'(a[30:23]) - 126;
    idx = e / 32;
    sh  = e % 32;
    h = tw(idx - 1); m = tw(idx); l = tw(idx + 1); x = tw(idx + 2);
    if (sh != 0) begin
      h2 = (h << sh) | (m >> (32 - sh));
      m2 = (m << sh) | (l >> (32 - sh));
      l2 = (l << sh) | (x >> (32 - sh));
      h = h2; m = m2; l = l2;
    end
    full = {96'h0, ia} * {32'h0, h, m, l};
    p = full[95:32];
    q = p[63:62] + {1'b0, p[61]};
    r = {{2{p[61]}}, p[61:0]};
    if (a[31]) begin
      q = 2'd0 - q;
      r = 64'd0 - r;
    end
  endtask

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic run_one(input logic [31:0] a, input string rtag, input bit poke);
    logic [1:0] q; logic [63:0] r; logic byp, spc;
    int lat;
    expect_of(a, q, r, byp, spc);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_angle = a;
    @(negedge clk);
    check("R1 ready low after accept", {63'h0, in_ready}, 64'h0);
    if (poke) begin
      in_valid = 1'b1; in_angle = ~a;
    end else begin
      in_valid = 1'b0;
    end
    lat = 0;
    while (!out_done && lat < 40) begin
      @(negedge clk); lat++;
    end
    in_valid = 1'b0;
    check("R2 latency", 64'(lat), 64'(NC + 1));
    check({rtag, " remainder"}, out_remainder, r);
    check((a[31] && !byp && !spc) ? "R9 quadrant" : "R8 quadrant", {62'h0, out_quadrant}, {62'h0, q});
    check("R3 bypass flag", {63'h0, out_bypass}, {63'h0, byp});
    check("R4 special flag", {63'h0, out_special}, {63'h0, spc});
    @(negedge clk);
    check("R2 done one cycle", {63'h0, out_done}, 64'h0);
    check("R2 outputs held", out_remainder, r);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [22:0] mants [6];
    mants = '{23'h000000, 23'h7FFFFF, 23'h2AAAAA, 23'h555555, 23'h12D687, 23'h6C3E01};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 ready", {63'h0, in_ready}, 64'h1);
    check("R10 done", {63'h0, out_done}, 64'h0);
    check("R10 remainder", out_remainder, 64'h0);
    check("R10 quadrant", {62'h0, out_quadrant}, 64'h0);

    run_one(32'h0000_0000, "R3", 0);
    run_one(32'h0000_0001, "R3", 0);
    run_one(32'h3F49_0FDB, "R3", 0);
    run_one(32'hBF00_0000, "R3", 0);
    run_one(32'h3F49_0FDC, "R7", 0);
    run_one(32'hBF49_0FDC, "R9", 0);
    run_one(32'h7F80_0000, "R4", 0);
    run_one(32'hFFC0_0001, "R4", 0);
    run_one(32'h4049_0FDB, "R1 ignored while busy", 1);
    @(negedge clk);
    check("R1 no extra done", {63'h0, out_done}, 64'h0);

    for (int ex = 126; ex <= 254; ex++) begin
      for (int mi = 0; mi < 6; mi++) begin
        for (int s = 0; s < 2; s++) begin
          string tg;
          if (mi == 0) tg = "R5";
          else if ((ex - 126) % 32 == 0 || ex < 158 || ex > 249) tg = "R6";
          else tg = "R7";
          if (s == 1) tg = "R9";
          run_one({s[0], ex[7:0], mants[mi]}, tg, 0);
        end
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule